// File: doc/BRIEF.md
# Erase-Count Pool Manager for Flash Wear Leveling

The block holds one erase counter for every erase block of a small flash array and splits the blocks into a cold group and a hot group. A block is cold when its count is at or below a stored mean erase count, and hot when its count is above it. The mean is not updated on every erase. A rebalance request starts a pass that visits one counter per clock cycle, adds the counters up and divides the total by the block count with a shift. When the pass ends, the mean and the hot/cold flag of every block are refreshed together.

Firmware reports each block erase on the erase input and marks blocks free or occupied. It asks for a free block through a single-cycle request. The grant comes from the cold group when possible: it returns the least-erased free cold block, and falls back to the least-erased free hot block. The block also compares the most-erased occupied block with the least-erased block. When the gap between their counts exceeds a programmable threshold, it names both blocks as a suggested data move.

Top module: `wear_pool_mgr`

## Requirements
- R1: After reset every counter is zero, every block is free, the mean is zero, the hot map is all zeros, and alloc_gnt, swap_vld and rebal_busy are low.
- R2: An erase event adds one to the counter of the named block. At the all-ones value the counter holds and does not wrap.
- R3: rebal_go while idle raises rebal_busy for exactly NBLK cycles. When the pass ends, mean_cnt is the sum of all counters divided by NBLK (rounded down). Bit i of hot_map becomes 1 when the count of block i is strictly above the new mean, and 0 when it is equal to or below the mean.
- R4: mean_cnt and hot_map change only at the end of a rebalance pass. Erases made between passes leave them unchanged.
- R5: An alloc_req is answered one cycle later with alloc_gnt high and alloc_idx set to the free block whose hot_map bit is 0 and whose count is lowest (lowest index on ties). The granted block becomes occupied.
- R6: When no free block has hot_map bit 0, the grant returns the free hot block with the lowest count (lowest index on ties).
- R7: alloc_gnt is high only in the cycle after an alloc_req, and only when at least one block was free.
- R8: mark_vld with mark_free=1 frees block mark_idx, and mark_free=0 occupies it. When a mark and a grant target the same block in the same cycle, the block ends up occupied.
- R9: swap_vld is high when at least one block is occupied and the largest occupied count minus the smallest count over all blocks is greater than swap_thr. swap_hot names the most-erased occupied block and swap_cold names the least-erased block, with the lowest index chosen on ties.
- R10: rebal_go while rebal_busy is high is ignored and does not lengthen the pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| erase_vld | input | 1 | An erase of block erase_idx happened |
| erase_idx | input | IW | Block that was erased |
| mark_vld | input | 1 | Set the state of block mark_idx |
| mark_idx | input | IW | Block whose state is set |
| mark_free | input | 1 | 1 marks the block free, 0 marks it occupied |
| alloc_req | input | 1 | Request one free block |
| alloc_gnt | output | 1 | Grant pulse, one cycle after a request |
| alloc_idx | output | IW | Granted block |
| rebal_go | input | 1 | Start a mean recomputation pass |
| rebal_busy | output | 1 | Pass in progress |
| mean_cnt | output | CW | Mean erase count from the last pass |
| hot_map | output | NBLK | Per-block hot flag from the last pass |
| swap_thr | input | CW | Count gap above which a move is suggested |
| swap_vld | output | 1 | Move suggestion valid |
| swap_hot | output | IW | Most-erased occupied block |
| swap_cold | output | IW | Least-erased block |

## Verification
On every cycle, the assertions check the following: the mean and hot map stay frozen outside the end of a pass, a grant only follows a request, a granted block is occupied, and a suggested move names an occupied block and two different blocks. The bench's scenarios show the rest. This covers the counter saturating, the exact pass length and the mean it produces, and the preference for cold blocks when grants are chosen. It also covers the fallback to hot blocks, a mark and a grant colliding on one block, and the threshold edge of the move suggestion. A reference model checks all of these after every step of a random run.

// File: rtl/wear_pool_mgr.sv
module wear_pool_mgr #(
  parameter int NBLK = 64,
  parameter int CW   = 16,
  localparam int IW  = $clog2(NBLK)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            erase_vld,
  input  logic [IW-1:0]   erase_idx,
  input  logic            mark_vld,
  input  logic [IW-1:0]   mark_idx,
  input  logic            mark_free,
  input  logic            alloc_req,
  output logic            alloc_gnt,
  output logic [IW-1:0]   alloc_idx,
  input  logic            rebal_go,
  output logic            rebal_busy,
  output logic [CW-1:0]   mean_cnt,
  output logic [NBLK-1:0] hot_map,
  input  logic [CW-1:0]   swap_thr,
  output logic            swap_vld,
  output logic [IW-1:0]   swap_hot,
  output logic [IW-1:0]   swap_cold
);
  localparam int SW = CW + IW;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0]   cnt_q [NBLK];
  logic [NBLK-1:0] free_q;
  logic [IW-1:0]   ptr_q;
  logic [SW-1:0]   sum_q;
  logic [SW-1:0]   sum_nx;
  logic [CW-1:0]   mean_nx;
  logic            last_step;

  assign sum_nx    = sum_q + SW'(cnt_q[ptr_q]);
  assign mean_nx   = CW'(sum_nx >> IW);
  assign last_step = rebal_busy && (ptr_q == IW'(NBLK - 1));

  logic            g_found;
  logic [IW-1:0]   g_idx;
  logic [CW:0]     g_key;
  logic            occ_any;
  logic [IW-1:0]   hi_idx, lo_idx;
  logic [CW-1:0]   hi_cnt, lo_cnt;

  always_comb begin
    g_found = 1'b0;
    g_idx   = '0;
    g_key   = '1;
    occ_any = 1'b0;
    hi_idx  = '0;
    hi_cnt  = '0;
    lo_idx  = '0;
    lo_cnt  = cnt_q[0];
    for (int i = 0; i < NBLK; i++) begin
      if (free_q[i] && (!g_found || {hot_map[i], cnt_q[i]} < g_key)) begin
        g_found = 1'b1;
        g_key   = {hot_map[i], cnt_q[i]};
        g_idx   = IW'(i);
      end
      if (!free_q[i] && (!occ_any || cnt_q[i] > hi_cnt)) begin
        occ_any = 1'b1;
        hi_cnt  = cnt_q[i];
        hi_idx  = IW'(i);
      end
      if (cnt_q[i] < lo_cnt) begin
        lo_cnt = cnt_q[i];
        lo_idx = IW'(i);
      end
    end
  end

  assign swap_vld  = occ_any && ((hi_cnt - lo_cnt) > swap_thr);
  assign swap_hot  = hi_idx;
  assign swap_cold = lo_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBLK; i++) cnt_q[i] <= '0;
    end else if (erase_vld && cnt_q[erase_idx] != CMAX) begin
      cnt_q[erase_idx] <= cnt_q[erase_idx] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_q    <= '1;
      alloc_gnt <= 1'b0;
      alloc_idx <= '0;
    end else begin
      if (mark_vld) free_q[mark_idx] <= mark_free;
      if (alloc_req && g_found) free_q[g_idx] <= 1'b0;
      alloc_gnt <= alloc_req && g_found;
      alloc_idx <= g_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rebal_busy <= 1'b0;
      ptr_q      <= '0;
      sum_q      <= '0;
      mean_cnt   <= '0;
      hot_map    <= '0;
    end else if (!rebal_busy) begin
      if (rebal_go) begin
        rebal_busy <= 1'b1;
        ptr_q      <= '0;
        sum_q      <= '0;
      end
    end else begin
      sum_q <= sum_nx;
      ptr_q <= ptr_q + 1'b1;
      if (last_step) begin
        rebal_busy <= 1'b0;
        mean_cnt   <= mean_nx;
        for (int i = 0; i < NBLK; i++) hot_map[i] <= cnt_q[i] > mean_nx;
      end
    end
  end

  // R4
  pools_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rebal_busy) |-> ($stable(hot_map) && $stable(mean_cnt)));

  // R7
  gnt_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_gnt |-> $past(alloc_req));

  // R5
  gnt_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_gnt && !$past(mark_vld) |-> !free_q[alloc_idx]);

  // R9
  swap_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_vld |-> (!free_q[swap_hot] && swap_hot != swap_cold));

endmodule

// File: tb/sim_wear_pool_mgr.sv
module sim_wear_pool_mgr;
  localparam int  NB = 16;
  localparam int  CW = 5;
  localparam int  IW = 4;
  localparam int  MX = 31;
  localparam time CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic erase_vld = 0, mark_vld = 0, mark_free = 0, alloc_req = 0, rebal_go = 0;
  logic [IW-1:0] erase_idx = 0, mark_idx = 0;
  logic [CW-1:0] swap_thr = 0;
  logic alloc_gnt, rebal_busy, swap_vld;
  logic [IW-1:0] alloc_idx, swap_hot, swap_cold;
  logic [CW-1:0] mean_cnt;
  logic [NB-1:0] hot_map;

  wear_pool_mgr #(.NBLK(NB), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .erase_vld(erase_vld), .erase_idx(erase_idx),
    .mark_vld(mark_vld), .mark_idx(mark_idx), .mark_free(mark_free),
    .alloc_req(alloc_req), .alloc_gnt(alloc_gnt), .alloc_idx(alloc_idx),
    .rebal_go(rebal_go), .rebal_busy(rebal_busy), .mean_cnt(mean_cnt),
    .hot_map(hot_map), .swap_thr(swap_thr), .swap_vld(swap_vld),
    .swap_hot(swap_hot), .swap_cold(swap_cold));

  always #(CLK_P/2) clk = ~clk;

  int total = 0, fails = 0;
  bit finished = 0;
  int mcnt [NB];
  bit mfree [NB];
  bit mhot [NB];
  int mmean = 0;
  bit egnt;
  int eidx;

  task automatic chk(string req, int got, int exp);
    total++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int pick_free();
    int best = -1;
    for (int i = 0; i < NB; i++)
      if (mfree[i] && (best < 0 || (mhot[i]*64 + mcnt[i]) < (mhot[best]*64 + mcnt[best])))
        best = i;
    return best;
  endfunction

  function automatic int hot_pick();
    int h = -1;
    for (int i = 0; i < NB; i++)
      if (!mfree[i] && (h < 0 || mcnt[i] > mcnt[h])) h = i;
    return h;
  endfunction

  function automatic int cold_pick();
    int c = 0;
    for (int i = 1; i < NB; i++) if (mcnt[i] < mcnt[c]) c = i;
    return c;
  endfunction

  function automatic int hot_bits();
    int v = 0;
    for (int i = 0; i < NB; i++) if (mhot[i]) v |= (1 << i);
    return v;
  endfunction

  task automatic step(bit ev, int ei, bit mv, int mi, bit mf, bit ar);
    int g;
    @(negedge clk);
    erase_vld = ev; erase_idx = IW'(ei);
    mark_vld = mv; mark_idx = IW'(mi); mark_free = mf;
    alloc_req = ar;
    g = pick_free();
    @(posedge clk);
    egnt = ar && (g >= 0);
    eidx = g;
    if (mv) mfree[mi] = mf;
    if (egnt) mfree[g] = 1'b0;
    if (ev && mcnt[ei] < MX) mcnt[ei]++;
    #1;
    erase_vld = 0; mark_vld = 0; alloc_req = 0;
  endtask

  task automatic check_all(string tag);
    int h, c;
    bit sv;
    h = hot_pick();
    c = cold_pick();
    sv = (h >= 0) && ((mcnt[h] - mcnt[c]) > int'(swap_thr));
    chk({tag, " R7 gnt"}, int'(alloc_gnt), int'(egnt));
    if (egnt) chk({tag, " R5 idx"}, int'(alloc_idx), eidx);
    chk({tag, " R9 swap_vld"}, int'(swap_vld), int'(sv));
    if (sv) begin
      chk({tag, " R9 swap_hot"}, int'(swap_hot), h);
      chk({tag, " R9 swap_cold"}, int'(swap_cold), c);
    end
    chk({tag, " R4 mean"}, int'(mean_cnt), mmean);
    chk({tag, " R4 hot"}, int'(hot_map), hot_bits());
  endtask

  task automatic rebalance(bit extra_go);
    int n = 0, s = 0;
    @(negedge clk);
    rebal_go = 1;
    @(posedge clk);
    #1;
    rebal_go = 0;
    while (rebal_busy && n < 4 * NB) begin
      if (extra_go && n == 3) rebal_go = 1;
      @(posedge clk);
      #1;
      rebal_go = 0;
      n++;
    end
    chk(extra_go ? "R10 pass length" : "R3 pass length", n, NB);
    for (int i = 0; i < NB; i++) s += mcnt[i];
    mmean = s / NB;
    for (int i = 0; i < NB; i++) mhot[i] = mcnt[i] > mmean;
    chk("R3 mean", int'(mean_cnt), mmean);
    chk("R3 hot map", int'(hot_map), hot_bits());
    egnt = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NB; i++) begin mcnt[i] = 0; mfree[i] = 1; mhot[i] = 0; end
    egnt = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 gnt", int'(alloc_gnt), 0);
    chk("R1 swap", int'(swap_vld), 0);
    chk("R1 busy", int'(rebal_busy), 0);
    chk("R1 mean", int'(mean_cnt), 0);
    chk("R1 hot", int'(hot_map), 0);

    // R2 saturation: 40 erases on block 3 saturate at 31, mean 31/16 = 1
    for (int k = 0; k < 40; k++) step(1, 3, 0, 0, 0, 0);
    rebalance(0);
    chk("R2 saturated mean", int'(mean_cnt), 1);
    chk("R2 saturated hot", int'(hot_map), 1 << 3);

    // R9 threshold edge
    step(0, 0, 1, 3, 0, 0);
    swap_thr = 30;
    step(0, 0, 0, 0, 0, 0);
    chk("R9 gap above thr", int'(swap_vld), 1);
    chk("R9 hot block", int'(swap_hot), 3);
    chk("R9 cold block", int'(swap_cold), 0);
    swap_thr = 31;
    step(0, 0, 0, 0, 0, 0);
    chk("R9 gap at thr", int'(swap_vld), 0);

    // R4 erases between passes leave mean and hot map
    for (int k = 0; k < 5; k++) step(1, 5, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0); step(1, 1, 0, 0, 0, 0); step(1, 2, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0); step(1, 1, 0, 0, 0, 0);
    check_all("R4 frozen");

    // R5 least-erased free cold block: block 4
    step(0, 0, 0, 0, 0, 1);
    chk("R5 grant", int'(alloc_gnt), 1);
    chk("R5 grant idx", int'(alloc_idx), 4);

    // R6 only hot block 3 free
    for (int i = 0; i < NB; i++) step(0, 0, 1, i, i == 3, 0);
    step(0, 0, 0, 0, 0, 1);
    chk("R6 fallback grant", int'(alloc_gnt), 1);
    chk("R6 fallback idx", int'(alloc_idx), 3);

    // R7 nothing free
    step(0, 0, 0, 0, 0, 1);
    chk("R7 no free no gnt", int'(alloc_gnt), 0);

    // R8 mark free and grant of the same block collide
    step(0, 0, 1, 7, 1, 0);
    step(0, 0, 1, 7, 1, 1);
    chk("R8 collide grant", int'(alloc_gnt), 1);
    chk("R8 collide idx", int'(alloc_idx), 7);
    step(0, 0, 0, 0, 0, 1);
    chk("R8 block stays busy", int'(alloc_gnt), 0);

    // R10 second go ignored
    rebalance(1);

    // random run
    swap_thr = 6;
    for (int it = 0; it < 600; it++) begin
      int r = int'($urandom_range(0, 99));
      if (r < 3) rebalance(0);
      else begin
        step($urandom_range(0, 1), int'($urandom_range(0, NB-1)),
             $urandom_range(0, 2) == 0, int'($urandom_range(0, NB-1)),
             $urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0);
        check_all("rand");
      end
    end

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule